// File: doc/BRIEF.md
# Indexed Postbyte Address Generator

This block turns one indexed-addressing postbyte into a 16-bit effective address. The postbyte selects a base register from the four index-capable registers (X, Y, SP, PC) and an offset. The offset can be a short constant held in the postbyte, a signed byte or a full word taken from the extension bytes, or one of the accumulators A, B or D (D being A in the high byte and B in the low byte). Auto-modify forms step X, Y or SP by -8..-1 or +1..+8 and return the new register value for write-back. Two indirect forms fetch a 16-bit pointer from memory through a request/valid handshake, and that pointer becomes the effective address.

The instruction sequencer pulses `start` with the postbyte, the extension bytes and the current register values. A single `done` pulse returns the address together with the write-back, the extra-cycle flag and the illegal flag. When `restricted` is high, the long-offset forms are refused: the block reports them as illegal and returns address 0.

Top module: `idx_addr_gen`

## Requirements
- R1: With postbyte bit 5 clear, bits 7:6 pick the base (0=X, 1=Y, 2=SP, 3=PC), and bits 4:0 are a two's-complement offset (-16..+15) added to the base.
- R2: With bit 5 set and bits 7:6 not 11, the form is auto-modify. If bit 3 is set, the step is the low nibble sign-extended (-8..-1); otherwise the step is the low nibble plus 1 (+1..+8). In the done cycle, `wb_en` is 1, `wb_sel` equals bits 7:6, and `wb_data` is the base plus the step.
- R3: In auto-modify, bit 4 = 0 (pre) gives the modified value as the address, and bit 4 = 1 (post) gives the unmodified base.
- R4: With bits 7:5 = 111, bits 4:3 pick the base. If bit 2 = 0, bit 1 = 0 and bits 2:0 are not 011, the offset is the first extension byte (`ext_word[15:8]`) extended to 9 bits, with postbyte bit 0 as the sign.
- R5: With bits 7:5 = 111, bit 2 = 0, bit 1 = 1 and bits 2:0 not 011, the offset is the full `ext_word`.
- R6: With bits 7:5 = 111 and bit 2 = 1, bits 1:0 = 00 add A, 01 add B and 10 add D. A and B are zero-extended.
- R7: With bits 7:5 = 111 and bits 2:0 = 011, the block raises `mem_req` with `mem_addr` equal to the base plus `ext_word`. It holds both until `mem_valid`, and `done` follows one cycle after `mem_valid` with `eff_addr` equal to `mem_rdata`.
- R8: With bits 7:5 = 111 and bits 2:0 = 111, the same memory read is made at the base plus D, and the word read becomes the address. This form is legal in restricted mode.
- R9: When `restricted` is 1, the 9-bit, 16-bit and 16-bit-indirect forms give `illegal`=1 and `eff_addr`=0, with no write-back and no memory request.
- R10: `extra_cyc` is 1 for the legal 9-bit, 16-bit, 16-bit-indirect and D-indirect forms, and 0 otherwise.
- R11: All address arithmetic wraps modulo 2^16.
- R12: After reset, `done`, `mem_req` and `busy` are 0. For non-indirect forms, `done` is a one-cycle pulse in the cycle after `start`. While `busy` is 1, `start` is ignored.
- R13: `wb_en` is 1 only in the `done` cycle of an auto-modify form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin decoding the presented postbyte |
| restricted | input | 1 | Refuse the long-offset forms |
| postbyte | input | 8 | Indexed postbyte |
| ext_word | input | 16 | Extension bytes: first in [15:8], second in [7:0] |
| reg_x | input | 16 | X register |
| reg_y | input | 16 | Y register |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter |
| acc_a | input | 8 | Accumulator A (D high byte) |
| acc_b | input | 8 | Accumulator B (D low byte) |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 16 | Pointer read address |
| mem_valid | input | 1 | Pointer read data valid |
| mem_rdata | input | 16 | Pointer read data |
| busy | output | 1 | Waiting for the pointer read |
| done | output | 1 | Result valid pulse |
| eff_addr | output | 16 | Effective address |
| wb_en | output | 1 | Register write-back enable |
| wb_sel | output | 2 | Write-back register (0=X, 1=Y, 2=SP) |
| wb_data | output | 16 | Write-back value |
| extra_cyc | output | 1 | Form costs one extra cycle |
| illegal | output | 1 | Form refused in restricted mode |

## Verification
The assertions check the handshake and flag rules on every cycle. The request holds steady until valid arrives, and the request falls only together with `done`. `done` is caused only by `start` or `mem_valid`, write-back appears only with `done`, and an illegal result carries address 0, no write-back and no extra cycle. The address arithmetic can only be shown by the bench's scenarios, which compare the results against an independent model: every offset form, the pre/post step encodings, the wrap at 0xFFFF and the pointer indirection with varied read latency. The bench also covers the rejection of a `start` pulse that arrives while the block is busy.

// File: rtl/idx_pkg.sv
// Shared types for the indexed address generator.
// Assumes a 16-bit address space and 8-bit accumulators.
package idx_pkg;
    typedef enum logic [3:0] {
        F_OFF5,
        F_AUTO,
        F_OFF9,
        F_OFF16,
        F_IND16,
        F_ACC_A,
        F_ACC_B,
        F_ACC_D,
        F_IND_D
    } idx_form_e;

    typedef struct packed {
        idx_form_e  form;
        logic [1:0] base_sel;
        logic       is_ind;
        logic       illegal;
        logic       extra;
        logic       post;
    } idx_dec_t;
endpackage

// File: rtl/idx_decode.sv
// Postbyte classifier: works out the addressing form, the base register,
// whether memory indirection is needed, and the restricted-mode and
// extra-cycle flags. Purely combinational.
module idx_decode
    import idx_pkg::*;
(
    input  logic [7:0] postbyte,
    input  logic       restricted,
    output idx_dec_t   dec
);
    idx_form_e  form;
    logic [1:0] bsel;
    logic       long_form;

    // Pick the form and the base register from the postbyte fields.
    always_comb begin
        form = F_OFF5;
        bsel = postbyte[7:6];
        if (!postbyte[5]) begin
            form = F_OFF5;
        end else if (postbyte[7:6] != 2'b11) begin
            form = F_AUTO;
        end else begin
            bsel = postbyte[4:3];
            if (postbyte[2:0] == 3'b011) begin
                form = F_IND16;
            end else if (!postbyte[2]) begin
                form = postbyte[1] ? F_OFF16 : F_OFF9;
            end else begin
                case (postbyte[1:0])
                    2'b00:   form = F_ACC_A;
                    2'b01:   form = F_ACC_B;
                    2'b10:   form = F_ACC_D;
                    default: form = F_IND_D;
                endcase
            end
        end
    end

    // Forms that carry extension offsets are refused in restricted mode.
    always_comb begin
        long_form    = (form == F_OFF9) || (form == F_OFF16) || (form == F_IND16);
        dec.form     = form;
        dec.base_sel = bsel;
        dec.is_ind   = (form == F_IND16) || (form == F_IND_D);
        dec.illegal  = restricted && long_form;
        dec.extra    = !dec.illegal && (long_form || (form == F_IND_D));
        dec.post     = postbyte[4];
    end
endmodule

// File: rtl/idx_calc.sv
// Address arithmetic: selects the base register, forms the offset for the
// decoded form, and produces the sum (the address, or the pointer location
// for indirect forms) and the auto-modify write-back value. Sums wrap.
module idx_calc
    import idx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ACC_W  = 8
) (
    input  idx_dec_t              dec,
    input  logic [3:0]            nibble,
    input  logic [4:0]            off5,
    input  logic                  sign9,
    input  logic [ADDR_W-1:0]     ext_word,
    input  logic [ADDR_W-1:0]     reg_x,
    input  logic [ADDR_W-1:0]     reg_y,
    input  logic [ADDR_W-1:0]     reg_sp,
    input  logic [ADDR_W-1:0]     reg_pc,
    input  logic [ACC_W-1:0]      acc_a,
    input  logic [ACC_W-1:0]      acc_b,
    output logic [ADDR_W-1:0]     sum,
    output logic [ADDR_W-1:0]     wb_value
);
    localparam int NREG  = 4;
    localparam int EXT_B = 8;

    logic [NREG-1:0][ADDR_W-1:0] bases;
    logic [ADDR_W-1:0]           base;
    logic [ADDR_W-1:0]           step;
    logic [ADDR_W-1:0]           offset;
    logic [ADDR_W-1:0]           acc_d;

    // Collect the index-capable registers in select order.
    always_comb begin
        bases[0] = reg_x;
        bases[1] = reg_y;
        bases[2] = reg_sp;
        bases[3] = reg_pc;
        base     = bases[dec.base_sel];
        acc_d    = ADDR_W'({acc_a, acc_b});
    end

    // Auto-modify step: negative nibble sign-extends, else nibble plus one.
    always_comb begin
        if (nibble[3])
            step = {{(ADDR_W-4){1'b1}}, nibble};
        else
            step = ADDR_W'(nibble) + ADDR_W'(1);
    end

    // Offset per form; accumulator offsets are zero-extended.
    always_comb begin
        case (dec.form)
            F_OFF5:  offset = {{(ADDR_W-5){off5[4]}}, off5};
            F_AUTO:  offset = dec.post ? '0 : step;
            F_OFF9:  offset = {{(ADDR_W-EXT_B){sign9}}, ext_word[ADDR_W-1 -: EXT_B]};
            F_OFF16: offset = ext_word;
            F_IND16: offset = ext_word;
            F_ACC_A: offset = ADDR_W'(acc_a);
            F_ACC_B: offset = ADDR_W'(acc_b);
            default: offset = acc_d;
        endcase
    end

    // Final modular sums.
    always_comb begin
        sum      = base + offset;
        wb_value = base + step;
    end
endmodule

// File: rtl/idx_seq.sv
// Result sequencer: registers the outcome of a decoded postbyte, runs the
// single pointer read for indirect forms, and emits the done pulse.
// Assumes start is only honoured while idle.
module idx_seq
    import idx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  idx_dec_t          dec,
    input  logic [ADDR_W-1:0] sum,
    input  logic [ADDR_W-1:0] wb_value,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              wb_en,
    output logic [1:0]        wb_sel,
    output logic [ADDR_W-1:0] wb_data,
    output logic              extra_cyc,
    output logic              illegal
);
    typedef enum logic {S_IDLE, S_MEM} seq_state_e;
    seq_state_e state;

    // Accept a postbyte, wait for the pointer read, publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            mem_req   <= 1'b0;
            mem_addr  <= '0;
            done      <= 1'b0;
            eff_addr  <= '0;
            wb_en     <= 1'b0;
            wb_sel    <= '0;
            wb_data   <= '0;
            extra_cyc <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            done  <= 1'b0;
            wb_en <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        extra_cyc <= dec.extra;
                        illegal   <= dec.illegal;
                        if (dec.is_ind && !dec.illegal) begin
                            state    <= S_MEM;
                            mem_req  <= 1'b1;
                            mem_addr <= sum;
                        end else begin
                            done     <= 1'b1;
                            eff_addr <= dec.illegal ? '0 : sum;
                            wb_en    <= (dec.form == F_AUTO);
                            wb_sel   <= dec.base_sel;
                            wb_data  <= wb_value;
                        end
                    end
                end
                default: begin
                    if (mem_valid) begin
                        state    <= S_IDLE;
                        mem_req  <= 1'b0;
                        done     <= 1'b1;
                        eff_addr <= mem_rdata;
                    end
                end
            endcase
        end
    end

    // Busy whenever the pointer read is outstanding.
    always_comb busy = (state == S_MEM);
endmodule

// File: rtl/idx_addr_gen.sv
// Indexed postbyte address generator top: wires the classifier, the
// arithmetic and the sequencer. Assumes the caller holds the register
// and extension inputs valid in the start cycle.
module idx_addr_gen
    import idx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              restricted,
    input  logic [7:0]        postbyte,
    input  logic [ADDR_W-1:0] ext_word,
    input  logic [ADDR_W-1:0] reg_x,
    input  logic [ADDR_W-1:0] reg_y,
    input  logic [ADDR_W-1:0] reg_sp,
    input  logic [ADDR_W-1:0] reg_pc,
    input  logic [ADDR_W/2-1:0] acc_a,
    input  logic [ADDR_W/2-1:0] acc_b,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              wb_en,
    output logic [1:0]        wb_sel,
    output logic [ADDR_W-1:0] wb_data,
    output logic              extra_cyc,
    output logic              illegal
);
    localparam int ACC_W = ADDR_W / 2;

    idx_dec_t          dec;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] wb_value;

    idx_decode u_dec (
        .postbyte   (postbyte),
        .restricted (restricted),
        .dec        (dec)
    );

    idx_calc #(.ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_calc (
        .dec      (dec),
        .nibble   (postbyte[3:0]),
        .off5     (postbyte[4:0]),
        .sign9    (postbyte[0]),
        .ext_word (ext_word),
        .reg_x    (reg_x),
        .reg_y    (reg_y),
        .reg_sp   (reg_sp),
        .reg_pc   (reg_pc),
        .acc_a    (acc_a),
        .acc_b    (acc_b),
        .sum      (sum),
        .wb_value (wb_value)
    );

    idx_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dec       (dec),
        .sum       (sum),
        .wb_value  (wb_value),
        .mem_valid (mem_valid),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .busy      (busy),
        .done      (done),
        .eff_addr  (eff_addr),
        .wb_en     (wb_en),
        .wb_sel    (wb_sel),
        .wb_data   (wb_data),
        .extra_cyc (extra_cyc),
        .illegal   (illegal)
    );
endmodule

// File: rtl/idx_addr_gen_chk.sv
// Port-level protocol checks for the indexed address generator.
module idx_addr_gen_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_valid,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] eff_addr,
    input logic              wb_en,
    input logic              extra_cyc,
    input logic              illegal
);
    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R7
    req_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_req) |-> done);

    // R12
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start || mem_valid));

    // R12
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R13
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // R9
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (eff_addr == '0 && !wb_en));

    // R10
    illegal_no_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> !extra_cyc);
endmodule

bind idx_addr_gen idx_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_idx_addr_gen.sv
module tb_idx_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        restricted = 1'b0;
    logic [7:0]  postbyte = '0;
    logic [15:0] ext_word = '0;
    logic [15:0] reg_x = '0, reg_y = '0, reg_sp = '0, reg_pc = '0;
    logic [7:0]  acc_a = '0, acc_b = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        busy, done, wb_en, extra_cyc, illegal;
    logic [15:0] eff_addr, wb_data;
    logic [1:0]  wb_sel;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    idx_addr_gen dut (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    // Independent model of the requirements.
    task automatic model(input logic [7:0] pb, input bit rs,
                         output logic [15:0] ea, output bit ind, output logic [15:0] ptr,
                         output bit wbe, output logic [1:0] wsel, output logic [15:0] wdat,
                         output bit ill, output bit ext, output string tag);
        logic [15:0] r[4];
        logic [15:0] b, st, d;
        r[0] = reg_x; r[1] = reg_y; r[2] = reg_sp; r[3] = reg_pc;
        d = {acc_a, acc_b};
        ind = 0; ptr = 0; wbe = 0; wsel = pb[7:6]; wdat = 0; ill = 0; ext = 0; ea = 0;
        if (pb[5] == 0) begin
            b = r[pb[7:6]];
            ea = b + {{11{pb[4]}}, pb[4:0]};
            tag = "R1";
        end else if (pb[7:6] != 2'b11) begin
            b = r[pb[7:6]];
            st = pb[3] ? {12'hFFF, pb[3:0]} : {12'h000, pb[3:0]} + 16'd1;
            wbe = 1; wdat = b + st;
            ea = pb[4] ? b : b + st;
            tag = pb[4] ? "R3" : "R2";
        end else begin
            b = r[pb[4:3]];
            wsel = pb[4:3];
            if (pb[2:0] == 3'b011) begin
                tag = "R7";
                if (rs) ill = 1; else begin ind = 1; ptr = b + ext_word; ext = 1; end
            end else if (pb[2] == 0) begin
                tag = pb[1] ? "R5" : "R4";
                if (rs) ill = 1;
                else begin
                    ext = 1;
                    ea = pb[1] ? b + ext_word : b + {{8{pb[0]}}, ext_word[15:8]};
                end
            end else begin
                tag = "R6";
                case (pb[1:0])
                    2'b00: ea = b + {8'h00, acc_a};
                    2'b01: ea = b + {8'h00, acc_b};
                    2'b10: ea = b + d;
                    default: begin ind = 1; ptr = b + d; ext = 1; tag = "R8"; end
                endcase
            end
            if (ill) tag = "R9";
        end
        if (ind) ea = memf(ptr);
    endtask

    task automatic run_op(input logic [7:0] pb, input bit rs, input int lat, input bit probe);
        logic [15:0] ea, ptr, wdat;
        bit ind, wbe, ill, ext;
        logic [1:0] wsel;
        string tag;
        @(negedge clk);
        postbyte = pb; restricted = rs; start = 1'b1;
        model(pb, rs, ea, ind, ptr, wbe, wsel, wdat, ill, ext, tag);
        @(negedge clk);
        start = 1'b0;
        if (ind) begin
            check(mem_req && !done && busy, {tag, " request raised"}, {mem_req, done, busy}, 3'b101);
            check(mem_addr == ptr, {tag, " pointer address"}, mem_addr, ptr);
            if (probe) begin
                // R12: start while busy must be ignored
                postbyte = 8'h20; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check(mem_req && !done, "R12 start ignored while busy", {mem_req, done}, 2'b10);
            end
            repeat (lat) begin
                @(negedge clk);
                check(mem_req && !done && mem_addr == ptr, {tag, " wait for valid"}, mem_addr, ptr);
            end
            mem_valid = 1'b1; mem_rdata = memf(ptr);
            @(negedge clk);
            mem_valid = 1'b0; mem_rdata = 16'h0;
            check(done && !mem_req, {tag, " done after valid"}, {done, mem_req}, 2'b10);
        end else begin
            check(done && !mem_req, {tag, " done next cycle"}, {done, mem_req}, 2'b10);
        end
        check(eff_addr == ea, {tag, " effective address"}, eff_addr, ea);
        // R13: write-back only for auto-modify
        check(wb_en == wbe, {tag, " R13 wb_en"}, wb_en, wbe);
        if (wbe) check(wb_sel == wsel && wb_data == wdat, {tag, " write-back"}, {wb_sel, wb_data}, {wsel, wdat});
        check(illegal == ill, {tag, " R9 illegal flag"}, illegal, ill);
        check(extra_cyc == ext, {tag, " R10 extra cycle"}, extra_cyc, ext);
        @(negedge clk);
        check(!done && !wb_en, "R12 done is one pulse", {done, wb_en}, 2'b00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R12 watchdog expired");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        check(!done && !mem_req && !busy, "R12 reset state", {done, mem_req, busy}, 3'b000);
        rst_n = 1'b1;
        reg_x = 16'h1000; reg_y = 16'h2000; reg_sp = 16'h3000; reg_pc = 16'h4000;
        acc_a = 8'h81; acc_b = 8'hF0; ext_word = 16'h80FE;
        // R1 directed forms
        run_op(8'h00, 0, 0, 0);
        run_op(8'h1F, 0, 0, 0);
        run_op(8'hD0, 0, 0, 0);
        // R2 / R3 step extremes
        run_op(8'h27, 0, 0, 0);
        run_op(8'h28, 0, 0, 0);
        run_op(8'h3F, 0, 0, 0);
        run_op(8'h70, 0, 0, 0);
        run_op(8'hA8, 0, 0, 0);
        // R4 / R5 / R6 / R7 / R8
        run_op(8'hE0, 0, 0, 0);
        run_op(8'hE1, 0, 0, 0);
        run_op(8'hEA, 0, 0, 0);
        run_op(8'hE4, 0, 0, 0);
        run_op(8'hED, 0, 0, 0);
        run_op(8'hF6, 0, 0, 0);
        run_op(8'hE3, 0, 2, 1);
        run_op(8'hFF, 0, 0, 0);
        // R9: restricted refuses long forms, accepts D-indirect
        run_op(8'hE3, 1, 0, 0);
        run_op(8'hE0, 1, 0, 0);
        run_op(8'hF2, 1, 0, 0);
        run_op(8'hE7, 1, 1, 0);
        // R11 wrap-around
        reg_x = 16'hFFFF; reg_sp = 16'h0000;
        run_op(8'h01, 0, 0, 0);
        run_op(8'h20, 0, 0, 0);
        run_op(8'hBF, 0, 0, 0);
        run_op(8'h9F, 0, 0, 0);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            reg_x = 16'($urandom); reg_y = 16'($urandom);
            reg_sp = 16'($urandom); reg_pc = 16'($urandom);
            acc_a = 8'($urandom); acc_b = 8'($urandom); ext_word = 16'($urandom);
            run_op(8'($urandom), ($urandom % 4) == 0, $urandom % 4, ($urandom % 8) == 0);
        end
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule